// File: doc/BRIEF.md
# Two-Channel Memory DMA Engine

This block copies data from one memory address to another with no processor help. It has two channels. Each channel holds a source pointer, a destination pointer, a 24-bit unit count and a control word. A shared operation register carries the master enable, and a shared priority register gives the interrupt level. Software programs the block through a word-addressed register port. The block then moves data over a memory master port. Each unit is 1, 2, 4 or 16 bytes, and a 16-byte unit is split into four 32-bit beats.

A channel runs in one of two ways. In auto-request mode it moves units back to back until its count reaches zero. In external mode it waits for a pulse on its request input and moves exactly one unit per pulse. When a channel finishes, it sets a sticky end flag. If the channel's interrupt enable is set, the block also raises a one-cycle interrupt request that carries that channel's vector and the shared level.

Top module: `dual_dma_engine`

## Requirements
- R1: After reset every register reads zero. `mem_rd`, `mem_wr` and `irq_req` are low.
- R2: While bit 0 of the operation register is 0, no channel issues a memory access. Setting the bit starts every channel that is armed in auto-request mode.
- R3: A channel may start only when control bit 0 (enable) is 1 and control bit 1 (end flag) is 0. A write to the operation register or to either control register runs the start check. A channel whose end flag is set does not start.
- R4: The count register keeps only the low 24 bits of a written value.
- R5: With control bit 9 (auto-request) set, the channel moves units until the count is zero and then sets its end flag. If it starts with a count of zero, it sets the end flag without any access.
- R6: Control bits 11:10 select the unit size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 16 bytes. For sizes 0 to 2, each unit lowers the count by 1. Bit 12 adds the unit size to the source and bit 13 subtracts it. Bit 14 adds the unit size to the destination and bit 15 subtracts it. A pointer with neither of its bits set stays fixed.
- R7: A 16-byte unit is four 32-bit beats at offsets 0, 4, 8 and 12. After the unit, the source always advances by 16, whatever bits 13:12 say. The destination moves by 16 according to bits 15:14. The count drops by 4 and stops at zero.
- R8: When the end flag is set and control bit 2 (interrupt enable) is 1, `irq_req` pulses for one cycle. `irq_vec` is the low 7 bits of that channel's vector register, and `irq_lvl` is the low 4 bits of the priority register. With bit 2 clear, no pulse is raised.
- R9: In external mode (bit 9 clear), each one-cycle pulse on `req_in[c]` moves exactly one unit. The pulse is ignored unless the channel is armed, that is, master enable is 1, enable is 1 and the end flag is 0. The end flag is set when the count reaches zero.
- R10: When both channels have work at the same time, channel 0 is served first.
- R11: The end flag stays set until software writes 0 to control bit 1.
- R12: Each beat is a read on `mem_rd`, followed in the next cycle by a write on `mem_wr`. The write carries the data that was read. `mem_size` is 0, 1 or 2 for 1, 2 or 4 bytes, and data sits in the low bytes.
- R13: Register word addresses are:
  - 0 to 3: source, destination, count and control of channel 0.
  - 4 to 7: source, destination, count and control of channel 1.
  - 8: vector of channel 0.
  - 9: vector of channel 1.
  - 10: operation register.
  - 11: priority register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| req_in | input | 2 | External request pulse, one per channel |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the cycle after `mem_rd` |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_vec | output | 7 | Interrupt vector |
| irq_lvl | output | 4 | Interrupt level |

## Verification
The bench targets these corner cases:
- A 16-byte unit whose source mode bits say decrement. A design that obeys those bits writes data taken from the wrong source addresses.
- A burst started with a count of 2. A design without the floor at zero wraps the count and runs on without end.
- A restart attempt while the end flag is set, and a request pulse that arrives after a channel has finished. A faulty design starts again, which shows up as an unexpected write or an extra interrupt.
- Both channels released on the same cycle by the master enable. Any other order of the writes breaks the scoreboard.
- A count written with its upper byte set, which must be read back truncated.

// File: rtl/dual_dma_engine.sv
module dual_dma_engine #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [1:0]    req_in,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          irq_req,
  output logic [6:0]    irq_vec,
  output logic [3:0]    irq_lvl
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  logic [AW-1:0] src_r [2];
  logic [AW-1:0] dst_r [2];
  logic [CW-1:0] cnt_r [2];
  logic [15:0]   ctl_r [2];
  logic [6:0]    vec_r [2];
  logic          opr_me;
  logic [3:0]    prio_r;
  logic [1:0]    run, pend, armed, want;
  logic          chk, cur, sel;
  logic [1:0]    beat;
  st_t           st;

  for (genvar c = 0; c < 2; c++) begin : g_arm
    assign armed[c] = opr_me && ctl_r[c][0] && !ctl_r[c][1];
    assign want[c]  = armed[c] && (run[c] || pend[c]);
  end
  assign sel = !want[0];

  wire [15:0]   cc    = ctl_r[cur];
  wire [1:0]    usz   = cc[11:10];
  wire          burst = (usz == 2'd3);
  wire          last  = !burst || (beat == 2'd3);
  wire [AW-1:0] offs  = burst ? AW'({beat, 2'b00}) : '0;
  wire [AW-1:0] step  = burst ? AW'(16) : (AW'(1) << usz);
  wire [AW-1:0] src_nx = burst ? src_r[cur] + AW'(16)
                       : src_r[cur] + (cc[12] ? step : '0) - (cc[13] ? step : '0);
  wire [AW-1:0] dst_nx = dst_r[cur] + (cc[14] ? step : '0) - (cc[15] ? step : '0);
  wire [CW-1:0] cnt_nx = burst ? ((cnt_r[cur] > CW'(4)) ? cnt_r[cur] - CW'(4) : '0)
                       : cnt_r[cur] - CW'(1);

  wire fin_idle = (st == S_IDLE) && (|want) && (cnt_r[sel] == '0);
  wire fin_wr   = (st == S_WR) && last && (cnt_nx == '0);
  wire fin      = fin_idle || fin_wr;
  wire fin_ch   = fin_idle ? sel : cur;

  assign mem_rd    = (st == S_RD);
  assign mem_wr    = (st == S_WR);
  assign mem_addr  = (mem_rd ? src_r[cur] : dst_r[cur]) + offs;
  assign mem_size  = burst ? 2'd2 : usz;
  assign mem_wdata = mem_rdata;

  always_comb begin
    reg_rdata = '0;
    if (!reg_addr[3]) begin
      case (reg_addr[1:0])
        2'd0: reg_rdata = 32'(src_r[reg_addr[2]]);
        2'd1: reg_rdata = 32'(dst_r[reg_addr[2]]);
        2'd2: reg_rdata = 32'(cnt_r[reg_addr[2]]);
        default: reg_rdata = 32'(ctl_r[reg_addr[2]]);
      endcase
    end else begin
      case (reg_addr[2:0])
        3'd0: reg_rdata = 32'(vec_r[0]);
        3'd1: reg_rdata = 32'(vec_r[1]);
        3'd2: reg_rdata = 32'(opr_me);
        3'd3: reg_rdata = 32'(prio_r);
        default: reg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        src_r[c] <= '0; dst_r[c] <= '0; cnt_r[c] <= '0;
        ctl_r[c] <= '0; vec_r[c] <= '0;
      end
      opr_me <= 1'b0; prio_r <= '0; run <= '0; pend <= '0; chk <= 1'b0;
      cur <= 1'b0; beat <= '0; st <= S_IDLE;
      irq_req <= 1'b0; irq_vec <= '0; irq_lvl <= '0;
    end else begin
      irq_req <= 1'b0;
      chk <= reg_wr && (reg_addr == 4'd3 || reg_addr == 4'd7 || reg_addr == 4'd10);
      if (reg_wr) begin
        if (!reg_addr[3]) begin
          case (reg_addr[1:0])
            2'd0: src_r[reg_addr[2]] <= reg_wdata[AW-1:0];
            2'd1: dst_r[reg_addr[2]] <= reg_wdata[AW-1:0];
            2'd2: cnt_r[reg_addr[2]] <= reg_wdata[CW-1:0];
            default: ctl_r[reg_addr[2]] <= reg_wdata[15:0];
          endcase
        end else begin
          case (reg_addr[2:0])
            3'd0: vec_r[0] <= reg_wdata[6:0];
            3'd1: vec_r[1] <= reg_wdata[6:0];
            3'd2: opr_me   <= reg_wdata[0];
            3'd3: prio_r   <= reg_wdata[3:0];
            default: ;
          endcase
        end
      end
      for (int c = 0; c < 2; c++) begin
        if (chk && armed[c] && ctl_r[c][9]) run[c] <= 1'b1;
        if (req_in[c] && armed[c] && !ctl_r[c][9]) pend[c] <= 1'b1;
      end
      case (st)
        S_IDLE: if (|want) begin
          cur  <= sel;
          beat <= '0;
          if (cnt_r[sel] != '0) st <= S_RD;
        end
        S_RD: st <= S_WR;
        default: begin
          if (!last) begin
            beat <= beat + 2'd1;
            st   <= S_RD;
          end else begin
            src_r[cur] <= src_nx;
            dst_r[cur] <= dst_nx;
            cnt_r[cur] <= cnt_nx;
            pend[cur]  <= 1'b0;
            st         <= S_IDLE;
          end
        end
      endcase
      if (fin) begin
        ctl_r[fin_ch][1] <= 1'b1;
        run[fin_ch]  <= 1'b0;
        pend[fin_ch] <= 1'b0;
        if (ctl_r[fin_ch][2]) begin
          irq_req <= 1'b1;
          irq_vec <= vec_r[fin_ch];
          irq_lvl <= prio_r;
        end
      end
    end
  end

  wire wr_ctl0 = reg_wr && (reg_addr == 4'd3);

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !opr_me) |=> !mem_rd); // R2
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd)); // R12
  AST_END_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_r[0][1] && !$past(ctl_r[0][1]) && !$past(wr_ctl0)) |-> (cnt_r[0] == '0)); // R5
  AST_IRQ_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_r[0][1] && !$past(ctl_r[0][1]) && !$past(wr_ctl0)) |-> (irq_req == ctl_r[0][2])); // R8
  AST_SRC_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !reg_wr) |=> $stable(src_r[0])); // R6
endmodule

// File: tb/sim_dual_dma_engine.sv
`timescale 1ns/1ps
module sim_dual_dma_engine;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [1:0] req_in = 0;
  logic mem_rd, mem_wr, irq_req;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [1:0] mem_size;
  logic [6:0] irq_vec;
  logic [3:0] irq_lvl;

  always #5 clk = ~clk;

  dual_dma_engine u0 (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .req_in, .mem_rd, .mem_wr, .mem_addr, .mem_size, .mem_wdata, .mem_rdata,
    .irq_req, .irq_vec, .irq_lvl);

  typedef struct packed { logic [31:0] a; logic [31:0] d; logic [1:0] z; } wr_t;
  wr_t q[$];
  int checks = 0, fails = 0, irq_n = 0;
  logic [6:0] irq_v = 0;
  logic [3:0] irq_l = 0;
  logic [7:0] mem [256];

  localparam logic [31:0] DE = 32'h1, TE = 32'h2, IE = 32'h4, AR = 32'h200;
  localparam logic [31:0] SINC = 32'h1000, SDEC = 32'h2000, DINC = 32'h4000, DDEC = 32'h8000;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] * 8'd37 + 8'd11;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] sa, input logic [31:0] da, input int z);
    wr_t w;
    w.a = da; w.z = 2'(z); w.d = 0;
    for (int i = 0; i < (1 << z); i++) w.d[8*i +: 8] = pat(sa + 32'(i));
    q.push_back(w);
  endtask

  task automatic add_units(input logic [31:0] s, input logic [31:0] d, input int z,
                           input int sm, input int dm, input int n);
    logic [31:0] ss = s, dd = d;
    for (int u = 0; u < n; u++) begin
      if (z == 3) begin
        for (int b = 0; b < 4; b++) push(ss + 32'(4*b), dd + 32'(4*b), 2);
        ss = ss + 32'd16;
        dd = dd + 32'(dm * 16);
      end else begin
        push(ss, dd, z);
        ss = ss + 32'(sm * (1 << z));
        dd = dd + 32'(dm * (1 << z));
      end
    end
  endtask

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    if (mem_rd)
      mem_rdata <= {mem[mem_addr[7:0]+8'd3], mem[mem_addr[7:0]+8'd2],
                    mem[mem_addr[7:0]+8'd1], mem[mem_addr[7:0]]};
    if (mem_wr) begin
      logic [31:0] mask;
      wr_t e;
      mask = (mem_size == 2'd0) ? 32'hFF : (mem_size == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
      for (int i = 0; i < (1 << mem_size); i++) mem[mem_addr[7:0] + 8'(i)] = mem_wdata[8*i +: 8];
      if (q.size() == 0) chk("R12 unexpected write", mem_addr, 32'hFFFF_FFFF);
      else begin
        e = q.pop_front();
        chk("R12 addr", mem_addr, e.a);
        chk("R12 size", 32'(mem_size), 32'(e.z));
        chk("R12 data", mem_wdata & mask, e.d);
      end
    end
    if (irq_req) begin irq_n++; irq_v = irq_vec; irq_l = irq_lvl; end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic settle(); repeat (80) @(negedge clk); endtask

  task automatic pulse(input int c);
    @(negedge clk); req_in[c] = 1'b1;
    @(negedge clk); req_in = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #1_500_000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] v;
    int n0;
    for (int i = 0; i < 256; i++) mem[i] = pat(32'(i));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 12; a++) begin rd(4'(a), v); chk("R1 reg", v, 0); end
    chk("R1 strobes", {30'b0, mem_rd | mem_wr, irq_req}, 0);

    // R5 R6 R8 R13 auto 4-byte increment
    wr(10, 1); wr(11, 32'h35); wr(8, 32'h85); wr(9, 32'h7A);
    wr(0, 32'h10); wr(1, 32'h80); wr(2, 3);
    add_units(32'h10, 32'h80, 2, 1, 1, 3);
    wr(3, DE | IE | AR | (2 << 10) | DINC | SINC);
    settle();
    rd(2, v); chk("R5 count zero", v, 0);
    rd(0, v); chk("R6 src inc", v, 32'h1C);
    rd(1, v); chk("R6 dst inc", v, 32'h8C);
    rd(3, v); chk("R5 end flag", v & TE, TE);
    chk("R8 irq count", irq_n, 1);
    chk("R8 vector", 32'(irq_v), 32'h05);
    chk("R8 level", 32'(irq_l), 32'h5);
    chk("R12 queue drained", q.size(), 0);
    settle();
    rd(3, v); chk("R11 end flag sticky", v & TE, TE);
    wr(3, 0); rd(3, v); chk("R11 end flag cleared", v, 0);

    // R2 master enable gate, 2-byte src decrement, dst fixed
    wr(10, 0);
    wr(4, 32'h20); wr(5, 32'hA0); wr(6, 2);
    wr(7, DE | IE | AR | (1 << 10) | SDEC);
    settle();
    rd(6, v); chk("R2 held while disabled", v, 2);
    add_units(32'h20, 32'hA0, 1, -1, 0, 2);
    wr(10, 1);
    settle();
    rd(6, v); chk("R2 count after enable", v, 0);
    rd(4, v); chk("R6 src dec", v, 32'h1C);
    rd(5, v); chk("R6 dst fixed", v, 32'hA0);
    chk("R8 vector ch1", 32'(irq_v), 32'h7A);
    chk("R2 queue drained", q.size(), 0);

    // R3 end flag blocks restart
    n0 = irq_n;
    wr(6, 3);
    wr(7, DE | TE | IE | AR | (1 << 10) | SDEC);
    settle();
    rd(6, v); chk("R3 no start with end flag", v, 3);
    chk("R3 no irq", irq_n, n0);

    // R6 R8 1-byte, src fixed, dst decrement, no irq
    wr(7, 0);
    wr(0, 32'h30); wr(1, 32'hC0); wr(2, 3);
    add_units(32'h30, 32'hC0, 0, 0, -1, 3);
    n0 = irq_n;
    wr(3, DE | AR | DDEC);
    settle();
    rd(0, v); chk("R6 src fixed", v, 32'h30);
    rd(1, v); chk("R6 dst dec", v, 32'hBD);
    rd(3, v); chk("R5 end flag 1B", v & TE, TE);
    chk("R8 no irq when disabled", irq_n, n0);
    chk("R6 queue drained", q.size(), 0);

    // R7 burst, source mode ignored
    wr(3, 0);
    wr(0, 32'h40); wr(1, 32'hD0); wr(2, 8);
    add_units(32'h40, 32'hD0, 3, 0, 1, 2);
    n0 = irq_n;
    wr(3, DE | IE | AR | (3 << 10) | SDEC | DINC);
    settle();
    rd(0, v); chk("R7 src +16", v, 32'h60);
    rd(1, v); chk("R7 dst +16", v, 32'hF0);
    rd(2, v); chk("R7 count", v, 0);
    chk("R7 irq", irq_n, n0 + 1);
    chk("R7 queue drained", q.size(), 0);

    // R7 burst count floor, dst decrement
    wr(3, 0);
    wr(0, 32'h00); wr(1, 32'hF0); wr(2, 2);
    add_units(32'h00, 32'hF0, 3, 0, -1, 1);
    wr(3, DE | AR | (3 << 10) | DDEC);
    settle();
    rd(2, v); chk("R7 count floor", v, 0);
    rd(0, v); chk("R7 src floor case", v, 32'h10);
    rd(1, v); chk("R7 dst -16", v, 32'hE0);
    chk("R7 floor queue drained", q.size(), 0);

    // R9 external request
    wr(3, 0); wr(7, 0);
    wr(4, 32'h60); wr(5, 32'h90); wr(6, 2);
    wr(7, DE | IE | (1 << 10) | SINC | DINC);
    settle();
    rd(6, v); chk("R9 waits for request", v, 2);
    n0 = irq_n;
    add_units(32'h60, 32'h90, 1, 1, 1, 1);
    pulse(1); settle();
    rd(6, v); chk("R9 one unit per pulse", v, 1);
    rd(7, v); chk("R9 end flag clear", v & TE, 0);
    add_units(32'h62, 32'h92, 1, 1, 1, 1);
    pulse(1); settle();
    rd(6, v); chk("R9 count zero", v, 0);
    rd(7, v); chk("R9 end flag", v & TE, TE);
    chk("R9 irq", irq_n, n0 + 1);
    pulse(1); settle();
    chk("R9 pulse ignored", irq_n, n0 + 1);
    rd(5, v); chk("R9 dst unchanged", v, 32'h94);

    // R10 fixed priority
    wr(10, 0); wr(3, 0); wr(7, 0);
    wr(0, 32'h00); wr(1, 32'h80); wr(2, 2);
    wr(4, 32'h08); wr(5, 32'h88); wr(6, 2);
    add_units(32'h00, 32'h80, 2, 1, 1, 2);
    add_units(32'h08, 32'h88, 2, 1, 1, 2);
    wr(3, DE | AR | (2 << 10) | SINC | DINC);
    wr(7, DE | AR | (2 << 10) | SINC | DINC);
    wr(10, 1);
    settle();
    chk("R10 queue drained", q.size(), 0);

    // R4 count width
    wr(3, 0);
    wr(2, 32'hFF00_0002);
    rd(2, v); chk("R4 count truncated", v, 2);
    wr(0, 32'h70); wr(1, 32'hB0);
    add_units(32'h70, 32'hB0, 0, 1, 1, 2);
    wr(3, DE | AR | SINC | DINC);
    settle();
    rd(2, v); chk("R4 count done", v, 0);
    chk("R4 queue drained", q.size(), 0);

    // R5 zero count auto start
    wr(3, 0); n0 = irq_n;
    wr(3, DE | IE | AR);
    settle();
    rd(3, v); chk("R5 zero count end", v & TE, TE);
    chk("R5 zero count irq", irq_n, n0 + 1);

    summary();
  end
endmodule